// File: doc/BRIEF.md
# One-Hot Two-Level Routing Multiplexer

This block is a programmable routing multiplexer of the kind placed in the connection points, switch points and local crossbars of a fine-grained reconfigurable fabric. It picks one of its data inputs and drives it onto a single output. The choice comes from a small configuration register and takes effect combinationally: once the register is loaded, the output follows the chosen input with no clock between them.

The inputs are split into equal groups. The first stage picks the same position inside every group. The second stage picks one group's result. Each stage is controlled by its own one-hot field in the configuration register, so the data path is only AND-OR gating with no binary decoder. If either field has no bit set, or more than one bit set, the block drives the output low and raises an error flag. The register can be loaded in parallel in one cycle or shifted in serially as part of a configuration chain. It clears to all zeros on reset, so the error flag stays high until a legal pattern is loaded.

Top module: `ohmux_route`

## Requirements
- R1: A synchronous active-low reset clears every configuration bit to 0. While the configuration is all zeros, cfg_err is 1, dout is 0 and cfg_shift_out is 0.
- R2: When cfg_par_we is 1 at a rising clock edge, the configuration register takes the value on cfg_par_data. The new selection is visible from that edge on.
- R3: When cfg_shift_en is 1 and cfg_par_we is 0 at an edge, the register shifts one place toward its top bit and cfg_shift_in enters bit 0. cfg_shift_out always shows the current top bit, CFG_W-1.
- R4: When cfg_par_we and cfg_shift_en are both 1 at the same edge, the parallel load takes effect and the shift is discarded.
- R5: The configuration width is CFG_W = GRP + NUM_GRP, where NUM_GRP = ceil(N_IN/GRP). Bit NUM_GRP+p selects position p within a group, and bit g selects group g. With exactly one bit set in each field, dout equals din[g*GRP+p].
- R6: dout follows a change on the selected input within the same clock cycle, with no clock edge in between.
- R7: If the position field (bits CFG_W-1..NUM_GRP) or the group field (bits NUM_GRP-1..0) has zero set bits or more than one set bit, cfg_err is 1 and dout is 0. Otherwise cfg_err is 0.
- R8: When N_IN is not a multiple of GRP, selecting a slot at index N_IN or above gives dout = 0.
- R9: With cfg_par_we and cfg_shift_en both 0, the configuration does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_par_we | input | 1 | Parallel load strobe |
| cfg_par_data | input | CFG_W | Parallel configuration word |
| cfg_shift_en | input | 1 | Serial shift enable |
| cfg_shift_in | input | 1 | Serial configuration bit, enters at bit 0 |
| cfg_shift_out | output | 1 | Current top configuration bit, for chaining |
| din | input | N_IN | Routing inputs |
| dout | output | 1 | Routed output |
| cfg_err | output | 1 | Configuration is not one-hot in both fields |

## Verification
A parallel load and a serial shift can both be requested for the same clock edge. The random stimulus raises both enables together in a share of its cycles, and a few directed cases do the same. The bench model gives the parallel word priority. The following cycle's dout, cfg_err and cfg_shift_out then show which of the two operations won: a shifted pattern would route a different input and put a different bit on the chain output.

// File: rtl/ohmux_pkg.sv
`timescale 1ns/1ps
// Package: shared sizing helpers for the one-hot routing multiplexer.
// Assumes positive integer arguments.
package ohmux_pkg;

    // Ceiling division, used to derive the group count from the input count.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/ohmux_cfg_reg.sv
`timescale 1ns/1ps
// Module: ohmux_cfg_reg
// Holds the configuration word. Supports a parallel load and a serial
// shift; the parallel load wins when both are requested. Reset is
// synchronous and active low, and clears the word to zero.
module ohmux_cfg_reg #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_we,
    input  logic [WIDTH-1:0] par_data,
    input  logic             shift_en,
    input  logic             shift_in,
    output logic [WIDTH-1:0] cfg_q,
    output logic             shift_out
);

    logic [WIDTH-1:0] cfg_nxt;

    // Next-state choice: parallel load first, then shift, else hold.
    always_comb begin
        if (par_we) begin
            cfg_nxt = par_data;
        end else if (shift_en) begin
            cfg_nxt = {cfg_q[WIDTH-2:0], shift_in};
        end else begin
            cfg_nxt = cfg_q;
        end
    end

    // Configuration storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_nxt;
        end
    end

    assign shift_out = cfg_q[WIDTH-1];

endmodule

// File: rtl/ohmux_onehot_det.sv
`timescale 1ns/1ps
// Module: ohmux_onehot_det
// Reports whether exactly one bit of a vector is set. It scans the vector
// once and records "some bit seen" and "a second bit seen".
module ohmux_onehot_det #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] vec,
    output logic             is_onehot
);

    logic seen;
    logic dup;

    // Linear scan that flags any set bit that follows an earlier one.
    always_comb begin
        seen = 1'b0;
        dup  = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (vec[i]) begin
                dup  = dup | seen;
                seen = 1'b1;
            end
        end
        is_onehot = seen & ~dup;
    end

endmodule

// File: rtl/ohmux_stage.sv
`timescale 1ns/1ps
// Module: ohmux_stage
// One level of the mux: an AND-OR of data and one-hot select lines.
// It assumes the select is one-hot; legality is judged elsewhere.
module ohmux_stage #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] sel,
    input  logic [WIDTH-1:0] data,
    output logic             y
);

    // Gate each input by its select line and merge the results.
    always_comb begin
        y = |(sel & data);
    end

endmodule

// File: rtl/ohmux_route.sv
`timescale 1ns/1ps
// Module: ohmux_route (top)
// Two-level one-hot routing multiplexer with its own configuration register.
// The upper GRP configuration bits pick a position inside every group, and
// the lower NUM_GRP bits pick the group. The output is forced to 0 and
// cfg_err is raised unless both fields are one-hot. Inputs that pad the
// last group are tied to 0.
module ohmux_route #(
    parameter  int N_IN    = 8,
    parameter  int GRP     = 4,
    localparam int NUM_GRP = ohmux_pkg::ceil_div(N_IN, GRP),
    localparam int CFG_W   = GRP + NUM_GRP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_par_we,
    input  logic [CFG_W-1:0] cfg_par_data,
    input  logic             cfg_shift_en,
    input  logic             cfg_shift_in,
    output logic             cfg_shift_out,
    input  logic [N_IN-1:0]  din,
    output logic             dout,
    output logic             cfg_err
);

    localparam int PAD_W = NUM_GRP * GRP;

    logic [CFG_W-1:0]   cfg_q;
    logic [GRP-1:0]     pos_sel;
    logic [NUM_GRP-1:0] grp_sel;
    logic [PAD_W-1:0]   din_pad;
    logic [NUM_GRP-1:0] lvl1;
    logic               lvl2;
    logic               pos_ok;
    logic               grp_ok;

    ohmux_cfg_reg #(.WIDTH(CFG_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .par_we    (cfg_par_we),
        .par_data  (cfg_par_data),
        .shift_en  (cfg_shift_en),
        .shift_in  (cfg_shift_in),
        .cfg_q     (cfg_q),
        .shift_out (cfg_shift_out)
    );

    assign pos_sel = cfg_q[CFG_W-1:NUM_GRP];
    assign grp_sel = cfg_q[NUM_GRP-1:0];

    // Pad the input vector with zeros up to a whole number of groups.
    generate
        if (PAD_W > N_IN) begin : g_pad
            assign din_pad = {{(PAD_W-N_IN){1'b0}}, din};
        end else begin : g_nopad
            assign din_pad = din;
        end
    endgenerate

    // First level: one position mux per group, all sharing pos_sel.
    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_lvl1
            ohmux_stage #(.WIDTH(GRP)) u_pos (
                .sel  (pos_sel),
                .data (din_pad[g*GRP +: GRP]),
                .y    (lvl1[g])
            );
        end
    endgenerate

    // Second level: pick one group result.
    ohmux_stage #(.WIDTH(NUM_GRP)) u_grp (
        .sel  (grp_sel),
        .data (lvl1),
        .y    (lvl2)
    );

    ohmux_onehot_det #(.WIDTH(GRP)) u_pos_chk (
        .vec       (pos_sel),
        .is_onehot (pos_ok)
    );

    ohmux_onehot_det #(.WIDTH(NUM_GRP)) u_grp_chk (
        .vec       (grp_sel),
        .is_onehot (grp_ok)
    );

    // Output gating: a bad pattern forces 0 and raises the flag.
    always_comb begin
        cfg_err = ~(pos_ok & grp_ok);
        dout    = lvl2 & ~cfg_err;
    end

endmodule

// File: rtl/ohmux_route_chk.sv
`timescale 1ns/1ps
// Module: ohmux_route_chk
// Property checker bound to ohmux_route. It watches the configuration
// register, the configuration controls and the output flags.
module ohmux_route_chk #(
    parameter int CFG_W   = 6,
    parameter int NUM_GRP = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_par_we,
    input logic [CFG_W-1:0] cfg_par_data,
    input logic             cfg_shift_en,
    input logic             cfg_shift_in,
    input logic             cfg_shift_out,
    input logic [CFG_W-1:0] cfg_q,
    input logic             dout,
    input logic             cfg_err
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_q == '0 && cfg_err)); // R1

    AST_PAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_par_we |=> (cfg_q == $past(cfg_par_data))); // R2

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_shift_en && !cfg_par_we) |=>
            (cfg_q == {$past(cfg_q[CFG_W-2:0]), $past(cfg_shift_in)})); // R3

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_par_we && cfg_shift_en) |=> (cfg_q == $past(cfg_par_data))); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_par_we && !cfg_shift_en) |=> $stable(cfg_q)); // R9

    AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err == !($countones(cfg_q[CFG_W-1:NUM_GRP]) == 1 &&
                     $countones(cfg_q[NUM_GRP-1:0]) == 1)); // R7

    AST_ERR_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !dout); // R7

    AST_CHAIN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift_out == cfg_q[CFG_W-1]); // R3

endmodule

bind ohmux_route ohmux_route_chk #(.CFG_W(CFG_W), .NUM_GRP(NUM_GRP)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_par_we    (cfg_par_we),
    .cfg_par_data  (cfg_par_data),
    .cfg_shift_en  (cfg_shift_en),
    .cfg_shift_in  (cfg_shift_in),
    .cfg_shift_out (cfg_shift_out),
    .cfg_q         (cfg_q),
    .dout          (dout),
    .cfg_err       (cfg_err)
);

// File: tb/test_ohmux_route.sv
`timescale 1ns/1ps
// Bench for ohmux_route: constrained random operations from a fixed seed
// plus directed corners. A second instance with 6 inputs checks padding.
module test_ohmux_route;

    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          par_we = 1'b0;
    logic [CW-1:0] par_data = '0;
    logic          sh_en = 1'b0;
    logic          sh_in = 1'b0;
    logic [7:0]    din = '0;
    logic [5:0]    din_p = '0;
    logic          sh_out, dout, err;
    logic          sh_out_p, dout_p, err_p;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [CW-1:0] model = '0;

    always #2 clk = ~clk;

    ohmux_route #(.N_IN(8), .GRP(4)) i_ohmux_route (
        .clk(clk), .rst_n(rst_n), .cfg_par_we(par_we), .cfg_par_data(par_data),
        .cfg_shift_en(sh_en), .cfg_shift_in(sh_in), .cfg_shift_out(sh_out),
        .din(din), .dout(dout), .cfg_err(err)
    );

    ohmux_route #(.N_IN(6), .GRP(4)) i_ohmux_route_pad (
        .clk(clk), .rst_n(rst_n), .cfg_par_we(par_we), .cfg_par_data(par_data),
        .cfg_shift_en(sh_en), .cfg_shift_in(sh_in), .cfg_shift_out(sh_out_p),
        .din(din_p), .dout(dout_p), .cfg_err(err_p)
    );

    // Expected flag: both fields must carry exactly one set bit.
    function automatic logic exp_err(input logic [CW-1:0] c);
        return !($countones(c[5:2]) == 1 && $countones(c[1:0]) == 1);
    endfunction

    // Expected output from the field rules, with zero padding above nin.
    function automatic logic exp_out(input logic [CW-1:0] c, input logic [7:0] d, input int nin);
        int idx = 0;
        if (exp_err(c)) return 1'b0;
        for (int p = 0; p < 4; p++) if (c[2+p]) idx += p;
        for (int g = 0; g < 2; g++) if (c[g]) idx += 4 * g;
        if (idx >= nin) return 1'b0;
        return d[idx];
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (cfg %b)", req, act, exp, model);
        end
    endtask

    // Compare every output of both instances against the model.
    task automatic check_all(input string req);
        chk({req, "/R5 dout"}, dout, exp_out(model, din, 8));
        chk({req, "/R7 err"}, err, exp_err(model));
        chk({req, "/R3 chain"}, sh_out, model[CW-1]);
        chk({req, "/R8 pad"}, dout_p, exp_out(model, {2'b00, din_p}, 6));
    endtask

    // Drive one edge's controls at the falling edge and update the model.
    task automatic step(input logic we, input logic [CW-1:0] d, input logic se, input logic si);
        @(negedge clk);
        par_we = we; par_data = d; sh_en = se; sh_in = si;
        @(posedge clk);
        if (we) model = d;                       // R2 / R4
        else if (se) model = {model[CW-2:0], si}; // R3
        #1;
        par_we = 1'b0; sh_en = 1'b0;
    endtask

    function automatic logic [CW-1:0] legal_cfg();
        return {4'(1 << ($urandom % 4)), 2'(1 << ($urandom % 2))};
    endfunction

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 err", err, 1'b1);
        chk("R1 dout", dout, 1'b0);
        chk("R1 chain", sh_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        din = 8'hFF; #1;
        chk("R1 dout zero cfg", dout, 1'b0);

        // Directed: parallel load of position 1, group 1 -> input 5.
        step(1'b1, 6'b0010_10, 1'b0, 1'b0);
        din = 8'b0010_0000; #1; check_all("R2 load");
        // R6: the routed input toggles with no clock edge in between.
        din = 8'b1101_1111; #1; chk("R6 fall", dout, 1'b0);
        din = 8'b0010_0000; #1; chk("R6 rise", dout, 1'b1);

        // R4: both enables together; the parallel word must win.
        step(1'b1, 6'b1000_01, 1'b1, 1'b1);
        din = 8'b0000_1000; #1; check_all("R4 both");
        chk("R4 dout", dout, 1'b1);

        // R3: serial load of 6'b010010 (position 2, group 1 -> input 6).
        for (int b = CW - 1; b >= 0; b--) step(1'b0, '0, 1'b1, 6'b010010 >> b);
        din = 8'b0100_0000; #1; check_all("R3 serial");
        chk("R3 dout", dout, 1'b1);

        // R9: idle cycles leave the selection untouched.
        step(1'b0, 6'b1111_11, 1'b0, 1'b1);
        #1; check_all("R9 idle");
        chk("R9 dout", dout, 1'b1);

        // R7 corners: empty and multi-hot fields.
        din = 8'hFF;
        step(1'b1, 6'b0000_01, 1'b0, 1'b0); #1; check_all("R7 pos empty");
        step(1'b1, 6'b0100_11, 1'b0, 1'b0); #1; check_all("R7 grp multi");
        step(1'b1, 6'b0110_10, 1'b0, 1'b0); #1; check_all("R7 pos multi");
        step(1'b1, 6'b1000_00, 1'b0, 1'b0); #1; check_all("R7 grp empty");

        // R8: slot 7 exists in the full instance but is padding in the small one.
        step(1'b1, 6'b1000_10, 1'b0, 1'b0);
        din = 8'h80; din_p = 6'h3F; #1;
        check_all("R8 slot7");
        chk("R8 pad zero", dout_p, 1'b0);

        // Constrained random mix of loads, shifts, collisions and idle cycles.
        for (int it = 0; it < 400; it++) begin
            int op = $urandom % 8;
            logic [CW-1:0] w = ($urandom % 2) ? legal_cfg() : CW'($urandom);
            case (op)
                0, 1, 2: step(1'b1, w, 1'b0, 1'b0);
                3, 4:    step(1'b0, w, 1'b1, 1'($urandom));
                5:       step(1'b1, w, 1'b1, 1'($urandom));
                default: step(1'b0, w, 1'b0, 1'($urandom));
            endcase
            din = 8'($urandom); din_p = 6'($urandom); #1;
            check_all("RND");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule